// File: doc/BRIEF.md
# Bit-Interleaved Loop Channel Demultiplexer

A station on a serial loop sees one bit per clock. Sixteen logical channels share the line one bit at a time, so each channel holds one bit position in every 16-bit frame. A frame-alignment pulse from the loop master marks position zero. The block keeps a position counter locked to that pulse. It decides which positions belong to this station and assembles the bits found there into 36-bit words: a 4-bit supervision field followed by a 32-bit data word, sent most significant bit first. Each finished word is handed to a consumer through a valid/ready pair.

The same position logic drives a transmit path. On its own positions the station sends its queued word. On every other position it copies the incoming bit to the outgoing line in the same cycle. A station can gang 2 or 4 evenly spaced positions per frame into one channel. This doubles or quadruples its rate, for example 4 or 8 Mbps instead of 2 Mbps on a 32 Mbps line.

Words are framed on the owned bit stream. An idle line carries zeros. A word starts with a one that follows at least four zero bits, and the transmitter always sends four zero bits ahead of each word.

Top module: `loop_chan_demux`

## Requirements
- R1: After reset, rx_valid_o, overrun_o and resync_o are 0 and tx_ready_o is 1. No position is owned until the first sync pulse, so tx_bit_o equals rx_bit_i.
- R2: The bit in the cycle where sync_i is high is position 0, and later cycles count up by one, wrapping after 15. The station locks on the first sync pulse.
- R3: Ownership of a position depends on the gang code gang_i. Code 0 means the position equals chan_i. Code 1 means position[2:0] equals chan_i[2:0], which gives positions n and n+8. Codes 2 and 3 mean position[1:0] equals chan_i[1:0], which gives n, n+4, n+8 and n+12.
- R4: A received word is 36 consecutive owned bits, first bit as word bit 35, supervision first. It starts only on a one after at least 4 consecutive zero owned bits, so bit 35 of every word is 1.
- R5: A finished word is held on rx_word_o with rx_valid_o high until rx_ready_i is sampled high.
- R6: If a word finishes while the previous one is still valid and rx_ready_i is low, the new word replaces it and overrun_o is high for one cycle after the completing edge.
- R7: A sync pulse while locked at any expected position other than 0 pulses resync_o for one cycle. It realigns the counter to 0, discards the partial word and restarts the zero-run count, so the partial word is never presented.
- R8: A transmit word is taken when tx_valid_i and tx_ready_o are both high. Its owned positions then carry 4 zeros, a one, and tx_word_i[34:0] MSB first, so bit 35 is forced to 1. tx_ready_o stays low until all 40 bits are sent.
- R9: In the same cycle, tx_bit_o equals rx_bit_i on every position that is not owned. Owned positions send 0 when no word is queued.
- R10: Ones on owned positions that do not follow 4 consecutive zeros start no word and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line bit clock, one loop bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Incoming loop bit |
| sync_i | input | 1 | Frame pulse, high on the position-0 bit |
| chan_i | input | 4 | Base channel number of this station |
| gang_i | input | 2 | 0: one position, 1: two positions, 2/3: four positions per frame |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_word_o | output | 36 | Received word, supervision in [35:32] |
| overrun_o | output | 1 | One-cycle pulse: unread word was replaced |
| resync_o | output | 1 | One-cycle pulse: sync pulse arrived off frame start |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmitter idle and able to take a word |
| tx_word_i | input | 36 | Word to transmit |
| tx_bit_o | output | 1 | Outgoing loop bit |

## Verification
The hardest state to reach from the ports is a sync pulse landing in the middle of a word. The position counter must be locked, the receiver must already have accepted the start marker, and the pulse must fall off frame start. The bench sends part of a word on the station's positions and then drives sync_i at a non-zero position. It checks that the resync pulse appears, that the counter realigns, and that no word appears until a fresh word with its own zero lead-in has arrived. Ganged modes are covered by changing chan_i and gang_i between words. In each mode, the bits the bench drives on foreign positions must reappear unchanged on tx_bit_o.

// File: rtl/loop_pkg.sv
package loop_pkg;
  localparam int unsigned NCH_DEF   = 16;
  localparam int unsigned SUP_W_DEF = 4;
  localparam int unsigned DAT_W_DEF = 32;
  localparam int unsigned LEAD_DEF  = 4;

  typedef enum logic [1:0] {
    GANG_X1  = 2'd0,
    GANG_X2  = 2'd1,
    GANG_X4  = 2'd2,
    GANG_X4B = 2'd3
  } gang_e;
endpackage

// File: rtl/loop_slot_ctr.sv
module loop_slot_ctr
  import loop_pkg::*;
#(
  parameter int unsigned NCH   = NCH_DEF,
  localparam int unsigned POS_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [POS_W-1:0] chan_i,
  input  logic [1:0]       gang_i,
  output logic             owned_o,
  output logic             resync_o
);
  logic [POS_W-1:0] pos_q, pos_eff, mask;
  logic             locked_q;

  always_comb begin
    pos_eff = sync_i ? '0 : pos_q;
    unique case (gang_e'(gang_i))
      GANG_X1: mask = {POS_W{1'b1}};
      GANG_X2: mask = {POS_W{1'b1}} >> 1;
      default: mask = {POS_W{1'b1}} >> 2;
    endcase
    owned_o  = (locked_q | sync_i) && (((pos_eff ^ chan_i) & mask) == '0);
    resync_o = sync_i & locked_q & (pos_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      pos_q    <= pos_eff + 1'b1;
      locked_q <= locked_q | sync_i;
    end
  end
endmodule

// File: rtl/loop_rx_asm.sv
module loop_rx_asm #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned LEAD_W = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1),
  localparam int unsigned ZR_W  = $clog2(LEAD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              bit_i,
  input  logic              abort_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overrun_o,
  output logic              busy_o
);
  logic              busy_q, valid_q, ovr_q, done;
  logic [CNT_W-1:0]  cnt_q;
  logic [ZR_W-1:0]   zrun_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;

  assign done      = slot_i & busy_q & ~abort_i & (cnt_q == CNT_W'(WORD_W - 1));
  assign valid_o   = valid_q;
  assign word_o    = word_q;
  assign overrun_o = ovr_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      zrun_q <= '0;
      sh_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      zrun_q <= '0;
    end else if (slot_i) begin
      if (busy_q) begin
        sh_q  <= {sh_q[WORD_W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (done) begin
          busy_q <= 1'b0;
          zrun_q <= '0;
        end
      end else if (!bit_i) begin
        if (zrun_q != ZR_W'(LEAD_W)) zrun_q <= zrun_q + 1'b1;
      end else if (zrun_q == ZR_W'(LEAD_W)) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        sh_q   <= {{(WORD_W-2){1'b0}}, 1'b1};
      end else begin
        zrun_q <= '0;
      end
    end
  end

  // output holding stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      if (done) begin
        word_q  <= {sh_q, bit_i};
        valid_q <= 1'b1;
        ovr_q   <= valid_q & ~ready_i;
      end else if (valid_q && ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/loop_tx_ser.sv
module loop_tx_ser #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned LEAD_W = 4,
  localparam int unsigned FR_W  = LEAD_W + WORD_W,
  localparam int unsigned CNT_W = $clog2(FR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic              bit_o
);
  logic            busy_q;
  logic [FR_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o = ~busy_q;
  assign bit_o   = busy_q & sh_q[FR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        // zero lead-in, then forced start marker
        sh_q   <= {{LEAD_W{1'b0}}, 1'b1, word_i[WORD_W-2:0]};
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (slot_i) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FR_W - 1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_chan_demux.sv
module loop_chan_demux
  import loop_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned SUP_W  = SUP_W_DEF,
  parameter int unsigned DAT_W  = DAT_W_DEF,
  parameter int unsigned LEAD_W = LEAD_DEF,
  localparam int unsigned POS_W  = $clog2(NCH),
  localparam int unsigned WORD_W = SUP_W + DAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              sync_i,
  input  logic [POS_W-1:0]  chan_i,
  input  logic [1:0]        gang_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              overrun_o,
  output logic              resync_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_bit_o
);
  logic slot_owned, resync_now, rx_busy, tx_own_bit, rsy_q;

  loop_slot_ctr #(.NCH(NCH)) u_slot (
    .clk_i, .rst_ni, .sync_i, .chan_i, .gang_i,
    .owned_o (slot_owned),
    .resync_o(resync_now)
  );

  loop_rx_asm #(.WORD_W(WORD_W), .LEAD_W(LEAD_W)) u_rx (
    .clk_i, .rst_ni,
    .slot_i   (slot_owned),
    .bit_i    (rx_bit_i),
    .abort_i  (resync_now),
    .ready_i  (rx_ready_i),
    .valid_o  (rx_valid_o),
    .word_o   (rx_word_o),
    .overrun_o(overrun_o),
    .busy_o   (rx_busy)
  );

  loop_tx_ser #(.WORD_W(WORD_W), .LEAD_W(LEAD_W)) u_tx (
    .clk_i, .rst_ni,
    .slot_i (slot_owned),
    .valid_i(tx_valid_i),
    .word_i (tx_word_i),
    .ready_o(tx_ready_o),
    .bit_o  (tx_own_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsy_q <= 1'b0;
    else         rsy_q <= resync_now;
  end

  assign resync_o = rsy_q;
  assign tx_bit_o = slot_owned ? tx_own_bit : rx_bit_i;
endmodule

// File: rtl/loop_chan_demux_chk.sv
module loop_chan_demux_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_o,
  input logic rx_ready_i,
  input logic rx_word_msb,
  input logic overrun_o,
  input logic resync_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_bit_o,
  input logic slot_owned,
  input logic rx_busy
);
  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);
  // R4
  rx_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_word_msb);
  // R6
  overrun_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> rx_valid_o);
  // R7
  resync_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> !rx_busy);
  // R8
  tx_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> !tx_ready_o);
  // R9
  tx_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o && slot_owned |-> !tx_bit_o);
endmodule

bind loop_chan_demux loop_chan_demux_chk u_chk (
  .clk_i, .rst_ni, .rx_valid_o, .rx_ready_i,
  .rx_word_msb(rx_word_o[WORD_W-1]),
  .overrun_o, .resync_o, .tx_valid_i, .tx_ready_o, .tx_bit_o,
  .slot_owned, .rx_busy
);

// File: tb/loop_chan_demux_test.sv
module loop_chan_demux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0, sync = 1'b0, rx_ready = 1'b0, tx_valid = 1'b0;
  logic [3:0]  chan = '0;
  logic [1:0]  gang = '0;
  logic [35:0] tx_word = '0;
  logic        rx_valid, overrun, resync, tx_ready, tx_bit;
  logic [35:0] rx_word;

  always #10 clk = ~clk;

  loop_chan_demux uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .sync_i(sync),
    .chan_i(chan), .gang_i(gang), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_word_o(rx_word), .overrun_o(overrun), .resync_o(resync),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_word_i(tx_word),
    .tx_bit_o(tx_bit)
  );

  int n_tests = 0, n_fail = 0;
  int gpos = 0, ncnt = 0, pt_err = 0, n_ovr = 0, n_rsy = 0, cap_n = 0;
  bit locked_b = 0, tx_cap_on = 0, done = 0;
  logic tx_cap [64];

  // {chan, gang, word}
  localparam logic [41:0] VEC [6] = '{
    {4'd0,  2'd0, 36'h8_1234_5678},
    {4'd12, 2'd0, 36'hF_0000_0001},
    {4'd3,  2'd1, 36'hA_DEAD_BEEF},
    {4'd13, 2'd1, 36'h9_8000_0000},
    {4'd2,  2'd2, 36'hC_5A5A_A5A5},
    {4'd15, 2'd3, 36'hB_FFFF_FFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit own_f(input int p);
    logic [3:0] m;
    m = (gang == 2'd0) ? 4'hF : (gang == 2'd1) ? 4'h7 : 4'h3;
    return locked_b && (((4'(p) ^ chan) & m) == 4'h0);
  endfunction

  task automatic drive(input logic b_own, input logic s, input int p, output bit own);
    logic b;
    if (s) locked_b = 1;
    own = own_f(p);
    ncnt++;
    b = own ? b_own : (ncnt[0] ^ ncnt[3]);
    @(negedge clk);
    rx_bit = b;
    sync = s;
    #2;
    if (!own && tx_bit !== b) pt_err++;
    if (own && tx_cap_on && cap_n < 64) begin tx_cap[cap_n] = tx_bit; cap_n++; end
    if (overrun) n_ovr++;
    if (resync) n_rsy++;
  endtask

  task automatic lstep(input logic b_own, output bit own);
    drive(b_own, gpos == 0, gpos, own);
    gpos = (gpos + 1) % 16;
  endtask

  task automatic send_owned(input logic b);
    bit own;
    own = 0;
    while (!own) lstep(b, own);
  endtask

  task automatic send_word(input logic [35:0] w);
    for (int i = 0; i < 4; i++) send_owned(1'b0);
    for (int i = 35; i >= 0; i--) send_owned(w[i]);
  endtask

  task automatic take_word;
    bit own;
    rx_ready = 1'b1;
    lstep(1'b0, own);
    rx_ready = 1'b0;
    lstep(1'b0, own);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit own;
    logic [35:0] w, txw;
    int o0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(overrun == 1'b0,  "R1 overrun", overrun, 0);
    chk(resync == 1'b0,   "R1 resync", resync, 0);
    // R1 R9 unlocked pass-through
    gpos = 5; pt_err = 0;
    for (int i = 0; i < 11; i++) lstep(1'b0, own);
    chk(pt_err == 0, "R1 unlocked pass-through", pt_err, 0);

    // R10 ones without a 4-zero lead-in are ignored (R2 locks on the sync sent next)
    chan = 4'd0; gang = 2'd0;
    for (int i = 0; i < 3; i++) send_owned(1'b0);
    for (int i = 0; i < 40; i++) send_owned(1'b1);
    for (int i = 0; i < 3; i++) send_owned(1'b0);
    chk(rx_valid == 1'b0, "R10 no word without lead-in", rx_valid, 0);

    // vector table: R2 R3 R4 R5 R8 R9
    foreach (VEC[v]) begin
      chan = VEC[v][41:38]; gang = VEC[v][37:36]; w = VEC[v][35:0];
      txw = w ^ 36'h7_F0F0_0F0F;
      pt_err = 0;
      tx_word = txw; tx_valid = 1'b1;
      lstep(1'b0, own);
      tx_valid = 1'b0; tx_cap_on = 1; cap_n = 0;
      lstep(1'b0, own);
      chk(tx_ready == 1'b0, "R8 tx busy after accept", tx_ready, 0);
      send_word(w);
      for (int i = 0; i < 4; i++) send_owned(1'b0);
      tx_cap_on = 0;
      chk(rx_valid == 1'b1 && rx_word == w, "R2 R3 R4 rx word", {rx_valid, rx_word}, {1'b1, w});
      begin
        bit ok;
        logic [39:0] got, exp;
        ok = (cap_n >= 40);
        exp = {4'b0000, 1'b1, txw[34:0]};
        got = '0;
        for (int i = 0; i < 40; i++) got[39-i] = tx_cap[i];
        chk(ok && got == exp, "R8 R3 tx sequence", got, exp);
      end
      chk(pt_err == 0 && tx_ready, "R9 pass-through and tx idle", pt_err, 0);
      lstep(1'b0, own);
      chk(rx_valid == 1'b1, "R5 word held without ready", rx_valid, 1);
      take_word();
      chk(rx_valid == 1'b0, "R5 valid drops after ready", rx_valid, 0);
    end

    // R6 overrun
    chan = 4'd6; gang = 2'd0;
    o0 = n_ovr;
    send_word(36'h8_0000_00AA);
    send_word(36'hE_0000_00BB);
    for (int i = 0; i < 4; i++) send_owned(1'b0);
    chk(n_ovr - o0 == 1, "R6 overrun pulse count", n_ovr - o0, 1);
    chk(rx_word == 36'hE_0000_00BB, "R6 newer word kept", rx_word, 36'hE_0000_00BB);
    take_word();

    // R7 resync in mid-word
    r0 = n_rsy;
    for (int i = 0; i < 4; i++) send_owned(1'b0);
    w = 36'hD_1111_2222;
    for (int i = 35; i >= 16; i--) send_owned(w[i]);
    if (gpos == 0) lstep(1'b0, own);
    drive(1'b0, 1'b1, 0, own);
    gpos = 1;
    for (int i = 35; i >= 16; i--) send_owned(w[i]);
    for (int i = 0; i < 4; i++) send_owned(1'b0);
    chk(n_rsy - r0 == 1, "R7 resync pulse", n_rsy - r0, 1);
    chk(rx_valid == 1'b0, "R7 partial word discarded", rx_valid, 0);
    send_word(36'h9_3333_4444);
    for (int i = 0; i < 4; i++) send_owned(1'b0);
    chk(rx_valid && rx_word == 36'h9_3333_4444, "R7 realigned word", rx_word, 36'h9_3333_4444);
    chk(n_rsy - r0 == 1, "R7 no further resync", n_rsy - r0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule